// File: doc/BRIEF.md
# 48-Bit Multiply-Accumulate Unit with Overflow Flags

This block multiplies two 32-bit operands and either adds the product to a single 48-bit accumulator or subtracts it. A 3-bit mode input chooses how the operands are read and how rounding is applied. The operands can be signed integers, unsigned integers, or signed Q31 fractions. In fractional mode the unit can round or truncate the product term before it is accumulated. Each strobed operation updates the accumulator and two registered status flags on the next clock edge. The first is a sticky overflow flag. The second is an extension flag, which reports that the result has grown past the narrow 32-bit or 40-bit view while the 48-bit value stays exact.

A combinational store path reads the registered accumulator and gives a 32-bit result for the current mode. In integer mode this is the low word. In fractional mode it is the fraction rounded to 32 bits or to 16 bits. A synchronous clear input empties the accumulator and every flag.

Top module: `mulacc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, `ovf_o` and `ext_o` become zero, and `store_o` then reads zero. This holds even if `vld_i` is high.
- R2: When `vld_i` is high and `clr_i` is low at a rising edge, the accumulator takes the 48-bit value acc + term if `sub_i`=0, or acc − term if `sub_i`=1. The sum wraps modulo 2^48.
- R3: Mode bits are `mode_i[2]`=unsigned, `mode_i[1]`=fractional and `mode_i[0]`=round. With `mode_i[2:1]`=00 the term is the low 48 bits of the two's-complement 64-bit product. This is a product overflow when the product lies outside the signed 48-bit range.
- R4: With `mode_i[2:1]`=10 the product and the accumulation are unsigned. Overflow means a product ≥ 2^48, a carry out of bit 47 on add, or a borrow on subtract.
- R5: With `mode_i[1]`=1 the operands are signed Q31 whatever `mode_i[2]` is. The doubled 64-bit product P supplies the term as P[63:24] sign-extended to 48 bits. When `mode_i[0]`=1, P[23] is added to the term (round half up). When `mode_i[0]`=0 the term is truncated. Two operands of 0x80000000 are a product overflow.
- R6: `ovf_o` rises one cycle after any strobed operation that has a product overflow or a signed accumulation overflow (48-bit wrap). It stays high until a clear or a reset.
- R7: After each strobed operation, `ext_o` shows whether the new accumulator fails to fit the narrow field. In signed integer mode the field is signed 32 bits, in unsigned integer mode it is unsigned 32 bits, and in fractional mode it is signed 40 bits. The accumulator value itself is not altered.
- R8: In integer mode (`mode_i[1]`=0), `store_o` equals accumulator bits [31:0].
- R9: In fractional mode with `mode_i[2]`=0, `store_o` is bits [39:8] of (acc + 2^7).
- R10: In fractional mode with `mode_i[2]`=1, `store_o[31:16]` is bits [39:24] of (acc + 2^23) and `store_o[15:0]` is zero.
- R11: When `clr_i` is high at a rising edge, the accumulator, `ovf_o` and `ext_o` become zero. Clear takes priority over a coincident `vld_i`, whose operation is discarded.
- R12: With `vld_i` and `clr_i` both low, the accumulator and both flags hold their values, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear accumulator and flags |
| vld_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 1 = subtract product, 0 = add |
| mode_i | input | 3 | [2] unsigned, [1] fractional, [0] round |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| acc_o | output | 48 | Registered accumulator |
| ovf_o | output | 1 | Sticky overflow flag |
| ext_o | output | 1 | Extension overflow flag |
| store_o | output | 32 | Rounded store value for the current mode |

## Verification
A clear and an operation strobe can arrive in the same cycle. The bench provokes this once with a non-zero accumulator and a set sticky flag, pairing the clear with a strobe that carries a non-zero product. It then judges the next edge: the accumulator, both flags and the store value must all read zero. A separate case drives reset together with a strobe and applies the same judgement.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

    localparam int OP_W     = 32;
    localparam int ACC_W    = 48;
    localparam int PROD_W   = 2 * OP_W;
    localparam int GUARD_W  = ACC_W - OP_W - 8;       // headroom above 40-bit fraction
    localparam int FRAC_W   = ACC_W - GUARD_W;        // 40
    localparam int FRAC_LSB = PROD_W - FRAC_W;        // 24
    localparam int ST_W     = OP_W;
    localparam int HALF_W   = ST_W / 2;
    localparam int ST32_LSB = FRAC_W - ST_W;          // 8
    localparam int ST16_LSB = FRAC_W - HALF_W;        // 24

    localparam logic [OP_W-1:0] OP_MIN = {1'b1, {(OP_W-1){1'b0}}};

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [PROD_W-1:0] prod_t;
    typedef logic [ST_W-1:0]   st_t;

    // Mode word layout: [2] unsigned, [1] fractional, [0] round
    typedef struct packed {
        logic uns;
        logic frac;
        logic rnd;
    } mode_t;

    typedef struct packed {
        acc_t term;
        logic povf;
    } term_t;

    typedef enum logic [1:0] {
        ARITH_SIGNED   = 2'b00,
        ARITH_UNSIGNED = 2'b01,
        ARITH_FRAC     = 2'b10
    } arith_e;

    function automatic arith_e arith_of(input logic uns, input logic frac);
        if (frac)     return ARITH_FRAC;
        else if (uns) return ARITH_UNSIGNED;
        else          return ARITH_SIGNED;
    endfunction

    function automatic logic prod_fits_signed(input prod_t p);
        prod_t s;
        s = prod_t'($signed(p) >>> (ACC_W - 1));
        return (s == '0) || (s == '1);
    endfunction

    function automatic logic prod_fits_unsigned(input prod_t p);
        return (p >> ACC_W) == '0;
    endfunction

    function automatic logic acc_fits_signed(input acc_t v, input int w);
        acc_t s;
        s = acc_t'($signed(v) >>> (w - 1));
        return (s == '0) || (s == '1);
    endfunction

    function automatic logic acc_fits_unsigned(input acc_t v, input int w);
        return (v >> w) == '0;
    endfunction

    function automatic acc_t round_up(input acc_t v, input int lsb);
        return v + (acc_t'(1) << (lsb - 1));
    endfunction

endpackage

// File: rtl/mulacc_mult.sv
module mulacc_mult
    import mulacc_pkg::*;
(
    input  logic [OP_W-1:0] opa_i,
    input  logic [OP_W-1:0] opb_i,
    input  mode_t           mode_i,
    output term_t           term_o
);

    arith_e kind;
    logic   ext_sign;
    prod_t  wide_a;
    prod_t  wide_b;
    prod_t  prod;
    prod_t  prod_dbl;
    acc_t   frac_trunc;
    logic   frac_half;

    always_comb begin
        kind     = arith_of(mode_i.uns, mode_i.frac);
        // one shared multiplier: operand extension picks the signedness
        ext_sign = (kind != ARITH_UNSIGNED);
        wide_a   = {{OP_W{ext_sign & opa_i[OP_W-1]}}, opa_i};
        wide_b   = {{OP_W{ext_sign & opb_i[OP_W-1]}}, opb_i};
        prod     = wide_a * wide_b;
        prod_dbl = prod << 1;

        frac_trunc = acc_t'($signed(prod_dbl) >>> FRAC_LSB);
        frac_half  = prod_dbl[FRAC_LSB-1];

        case (kind)
            ARITH_FRAC: begin
                term_o.term = frac_trunc + acc_t'(mode_i.rnd & frac_half);
                term_o.povf = (opa_i == OP_MIN) && (opb_i == OP_MIN);
            end
            ARITH_UNSIGNED: begin
                term_o.term = acc_t'(prod);
                term_o.povf = !prod_fits_unsigned(prod);
            end
            default: begin
                term_o.term = acc_t'(prod);
                term_o.povf = !prod_fits_signed(prod);
            end
        endcase
    end

endmodule

// File: rtl/mulacc_accum.sv
module mulacc_accum
    import mulacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  vld_i,
    input  logic  sub_i,
    input  logic  uns_i,
    input  logic  frac_i,
    input  term_t term_i,
    output acc_t  acc_o,
    output logic  ovf_o,
    output logic  ext_o
);

    arith_e           kind;
    logic [ACC_W:0]   wide;
    acc_t             res;
    logic             a_msb;
    logic             t_msb;
    logic             r_msb;
    logic             aovf;
    logic             ext_now;

    acc_t acc_q;
    logic sticky_q;
    logic ext_q;

    always_comb begin
        kind  = arith_of(uns_i, frac_i);
        wide  = sub_i ? ({1'b0, acc_q} - {1'b0, term_i.term})
                      : ({1'b0, acc_q} + {1'b0, term_i.term});
        res   = wide[ACC_W-1:0];
        a_msb = acc_q[ACC_W-1];
        t_msb = term_i.term[ACC_W-1];
        r_msb = res[ACC_W-1];

        if (kind == ARITH_UNSIGNED) begin
            aovf = wide[ACC_W];                 // carry out or borrow
        end else if (sub_i) begin
            aovf = (a_msb != t_msb) && (r_msb != a_msb);
        end else begin
            aovf = (a_msb == t_msb) && (r_msb != a_msb);
        end

        case (kind)
            ARITH_FRAC:     ext_now = !acc_fits_signed(res, FRAC_W);
            ARITH_UNSIGNED: ext_now = !acc_fits_unsigned(res, OP_W);
            default:        ext_now = !acc_fits_signed(res, OP_W);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q    <= '0;
            sticky_q <= 1'b0;
            ext_q    <= 1'b0;
        end else if (vld_i) begin
            acc_q    <= res;
            sticky_q <= sticky_q | term_i.povf | aovf;
            ext_q    <= ext_now;
        end
    end

    assign acc_o = acc_q;
    assign ovf_o = sticky_q;
    assign ext_o = ext_q;

endmodule

// File: rtl/mulacc_store.sv
module mulacc_store
    import mulacc_pkg::*;
(
    input  acc_t acc_i,
    input  logic uns_i,
    input  logic frac_i,
    output st_t  store_o
);

    acc_t r32;
    acc_t r16;

    always_comb begin
        r32 = round_up(acc_i, ST32_LSB);
        r16 = round_up(acc_i, ST16_LSB);
        if (!frac_i) begin
            store_o = ST_W'(acc_i);
        end else if (uns_i) begin
            store_o = {HALF_W'(r16 >> ST16_LSB), {HALF_W{1'b0}}};
        end else begin
            store_o = ST_W'(r32 >> ST32_LSB);
        end
    end

endmodule

// File: rtl/mulacc_core.sv
module mulacc_core
    import mulacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic              sub_i,
    input  logic [2:0]        mode_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              ovf_o,
    output logic              ext_o,
    output logic [ST_W-1:0]   store_o
);

    mode_t md;
    term_t term;
    acc_t  acc;

    assign md = mode_t'(mode_i);

    mulacc_mult u_mult (
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .mode_i (md),
        .term_o (term)
    );

    mulacc_accum u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .vld_i  (vld_i),
        .sub_i  (sub_i),
        .uns_i  (md.uns),
        .frac_i (md.frac),
        .term_i (term),
        .acc_o  (acc),
        .ovf_o  (ovf_o),
        .ext_o  (ext_o)
    );

    mulacc_store u_store (
        .acc_i   (acc),
        .uns_i   (md.uns),
        .frac_i  (md.frac),
        .store_o (store_o)
    );

    assign acc_o = acc;

endmodule

// File: rtl/mulacc_core_chk.sv
module mulacc_core_chk
    import mulacc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             vld_i,
    input logic [2:0]       mode_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             ovf_o,
    input logic             ext_o,
    input logic [ST_W-1:0]  store_o
);

    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_o == '0) && !ovf_o && !ext_o && (store_o == '0));

    assert_sticky_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!vld_i && !clr_i) |=> ($stable(acc_o) && $stable(ovf_o) && $stable(ext_o)));

    assert_ext_int_R7: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !clr_i && (mode_i == 3'b000)) |=>
        (ext_o == !((acc_o[ACC_W-1:OP_W-1] == '0) || (&acc_o[ACC_W-1:OP_W-1]))));

    assert_half_store_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_i[2] && mode_i[1]) |-> (store_o[HALF_W-1:0] == '0));

endmodule

bind mulacc_core mulacc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .vld_i   (vld_i),
    .mode_i  (mode_i),
    .acc_o   (acc_o),
    .ovf_o   (ovf_o),
    .ext_o   (ext_o),
    .store_o (store_o)
);

// File: tb/mulacc_core_bench.sv
module mulacc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        vld_i = 1'b0;
    logic        sub_i = 1'b0;
    logic [2:0]  mode_i = 3'b000;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [47:0] acc_o;
    logic        ovf_o;
    logic        ext_o;
    logic [31:0] store_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mulacc_core u_mulacc_core (
        .clk(clk), .rst(rst), .clr_i(clr_i), .vld_i(vld_i), .sub_i(sub_i),
        .mode_i(mode_i), .opa_i(opa_i), .opb_i(opb_i),
        .acc_o(acc_o), .ovf_o(ovf_o), .ext_o(ext_o), .store_o(store_o)
    );

    typedef struct packed {
        logic        clr;
        logic        vld;
        logic        sub;
        logic [2:0]  mode;
        logic [31:0] a;
        logic [31:0] b;
        logic [47:0] acc;
        logic        ovf;
        logic        ext;
        logic [31:0] st;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,3'b000,32'h0,32'h0,48'h0,1'b0,1'b0,32'h0,8'd11},                       // R11
        '{1'b0,1'b1,1'b0,3'b000,32'h3,32'h5,48'hF,1'b0,1'b0,32'hF,8'd3},                        // R3
        '{1'b0,1'b1,1'b1,3'b000,32'hFFFFFFFE,32'hA,48'h23,1'b0,1'b0,32'h23,8'd2},               // R2
        '{1'b0,1'b1,1'b0,3'b000,32'h10000,32'h10000,48'h0001_0000_0023,1'b0,1'b1,32'h23,8'd7},  // R7
        '{1'b0,1'b1,1'b1,3'b000,32'h10000,32'h10000,48'h23,1'b0,1'b0,32'h23,8'd7},              // R7
        '{1'b0,1'b1,1'b0,3'b100,32'hFFFFFFFF,32'h2,48'h0002_0000_0021,1'b0,1'b1,32'h21,8'd4},   // R4
        '{1'b0,1'b1,1'b1,3'b100,32'h3,32'hFFFFFFFF,48'hFFFF_0000_0024,1'b1,1'b1,32'h24,8'd4},   // R4
        '{1'b0,1'b0,1'b0,3'b100,32'hDEADBEEF,32'hCAFEF00D,48'hFFFF_0000_0024,1'b1,1'b1,32'h24,8'd12}, // R12
        '{1'b1,1'b1,1'b0,3'b000,32'h7,32'h7,48'h0,1'b0,1'b0,32'h0,8'd11},                       // R11
        '{1'b0,1'b1,1'b0,3'b010,32'h40000000,32'h40000000,48'h0020_0000_0000,1'b0,1'b0,32'h20000000,8'd5}, // R5
        '{1'b0,1'b1,1'b0,3'b011,32'h1,32'h00400000,48'h0020_0000_0001,1'b0,1'b0,32'h20000000,8'd5},        // R5
        '{1'b0,1'b1,1'b0,3'b010,32'h1,32'h00400000,48'h0020_0000_0001,1'b0,1'b0,32'h20000000,8'd5},        // R5
        '{1'b0,1'b1,1'b0,3'b110,32'h80000000,32'h80000000,48'hFFA0_0000_0001,1'b1,1'b0,32'hA0000000,8'd5}, // R5
        '{1'b0,1'b1,1'b1,3'b010,32'h40000000,32'h40000000,48'hFF80_0000_0001,1'b1,1'b0,32'h80000000,8'd9}, // R9
        '{1'b0,1'b1,1'b1,3'b010,32'h40000000,32'h40000000,48'hFF60_0000_0001,1'b1,1'b1,32'h60000000,8'd7}, // R7
        '{1'b1,1'b0,1'b0,3'b000,32'h0,32'h0,48'h0,1'b0,1'b0,32'h0,8'd11},                       // R11
        '{1'b0,1'b1,1'b0,3'b000,32'h7FFFFFFF,32'h7FFFFFFF,48'hFFFF_0000_0001,1'b1,1'b1,32'h1,8'd3},        // R3
        '{1'b1,1'b0,1'b0,3'b000,32'h0,32'h0,48'h0,1'b0,1'b0,32'h0,8'd11},                       // R11
        '{1'b0,1'b1,1'b0,3'b000,32'h7FFFFFFF,32'h10000,48'h7FFF_FFFF_0000,1'b0,1'b1,32'hFFFF0000,8'd7},    // R7
        '{1'b0,1'b1,1'b0,3'b000,32'h7FFFFFFF,32'h10000,48'hFFFF_FFFE_0000,1'b1,1'b0,32'hFFFE0000,8'd6},    // R6
        '{1'b1,1'b0,1'b0,3'b000,32'h0,32'h0,48'h0,1'b0,1'b0,32'h0,8'd11},                       // R11
        '{1'b0,1'b1,1'b0,3'b100,32'hFFFFFFFF,32'h10000,48'hFFFF_FFFF_0000,1'b0,1'b1,32'hFFFF0000,8'd4},    // R4
        '{1'b0,1'b1,1'b0,3'b100,32'h10000,32'h10000,48'h0000_FFFF_0000,1'b1,1'b0,32'hFFFF0000,8'd4},       // R4
        '{1'b1,1'b0,1'b0,3'b000,32'h0,32'h0,48'h0,1'b0,1'b0,32'h0,8'd11},                       // R11
        '{1'b0,1'b1,1'b0,3'b100,32'h01000000,32'h01000000,48'h0,1'b1,1'b0,32'h0,8'd4}           // R4
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic v, input logic s, input logic [2:0] m,
                         input logic [31:0] a, input logic [31:0] b);
        clr_i = c; vld_i = v; sub_i = s; mode_i = m; opa_i = a; opb_i = b;
        @(posedge clk);
        @(negedge clk);
        vld_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "acc", 64'(acc_o), 64'h0);
        check("R1", "ovf", 64'(ovf_o), 64'h0);
        check("R1", "ext", 64'(ext_o), 64'h0);
        check("R1", "store", 64'(store_o), 64'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string rq;
            string sq;
            rq = $sformatf("R%0d", VECS[i].req);
            drive(VECS[i].clr, VECS[i].vld, VECS[i].sub, VECS[i].mode, VECS[i].a, VECS[i].b);
            sq = !VECS[i].mode[1] ? "R8" : (VECS[i].mode[2] ? "R10" : "R9");
            check(rq,   $sformatf("vec%0d acc", i),   64'(acc_o),   64'(VECS[i].acc));
            check("R6", $sformatf("vec%0d ovf", i),   64'(ovf_o),   64'(VECS[i].ovf));
            check("R7", $sformatf("vec%0d ext", i),   64'(ext_o),   64'(VECS[i].ext));
            check(sq,   $sformatf("vec%0d store", i), 64'(store_o), 64'(VECS[i].st));
        end

        // R9 / R10: exact half rounds up
        drive(1'b1, 1'b0, 1'b0, 3'b000, 32'h0, 32'h0);
        drive(1'b0, 1'b1, 1'b0, 3'b000, 32'h80, 32'h1);
        check("R8", "int store 0x80", 64'(store_o), 64'h80);
        mode_i = 3'b010; #1;
        check("R9", "half lsb rounds up", 64'(store_o), 64'h1);
        mode_i = 3'b110; #1;
        check("R10", "below half stays", 64'(store_o), 64'h0);
        mode_i = 3'b000;
        drive(1'b1, 1'b0, 1'b0, 3'b000, 32'h0, 32'h0);
        drive(1'b0, 1'b1, 1'b0, 3'b000, 32'h00800000, 32'h1);
        mode_i = 3'b110; #1;
        check("R10", "half of 16-bit lsb", 64'(store_o), 64'h00010000);
        mode_i = 3'b010; #1;
        check("R9", "32-bit view", 64'(store_o), 64'h00008000);

        // R12: several idle cycles with changing operands
        mode_i = 3'b000;
        for (int k = 0; k < 4; k++) begin
            opa_i = 32'h1234 * (k + 1); opb_i = 32'hFFFF_0000 >> k;
            @(posedge clk); @(negedge clk);
        end
        check("R12", "idle acc", 64'(acc_o), 64'h00800000);

        // R1: reset wins over a strobe, after an overflow
        drive(1'b0, 1'b1, 1'b0, 3'b100, 32'h01000000, 32'h01000000);
        check("R6", "ovf set", 64'(ovf_o), 64'h1);
        rst = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 3'b000, 32'h5, 32'h5);
        rst = 1'b0;
        check("R1", "acc after rst", 64'(acc_o), 64'h0);
        check("R1", "ovf after rst", 64'(ovf_o), 64'h0);
        check("R1", "store after rst", 64'(store_o), 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule